// File: doc/BRIEF.md
# Deflection Drive Gate with Overvoltage Protection

This block sits between the raw drive generators of a display deflection controller and the output pins that switch the horizontal power transistor and the B+ DC/DC converter. When software clears the drive enable, both pins go to the level that turns the power transistor off. The horizontal off level is always high. The B+ off level follows a polarity bit. When the enable is set, the raw horizontal pulse train and the raw B+ pulse train pass through to the pins.

A 0-to-1 change of the enable raises a one-cycle soft-start request for the horizontal stage. When the converter runs in external-sawtooth mode, the same change also raises a request for the B+ converter. An overvoltage comparator input is synchronized and then caught in a sticky alarm flag. While that flag is set, the horizontal pin stays at its off level. Only a dedicated clear bit or reset removes the flag.

In external-sawtooth mode with phase mode on, the block also emits a one-cycle phase strobe on a chosen edge of the raw horizontal drive. The edge is either rising or falling, and the strobe is used to phase the B+ output.

Top module: `defl_drive_gate`

## Requirements
- R1: While `drv_en` is 0, `hout` is 1.
- R2: While `drv_en` is 0, `bout` equals `bpol` (1 = off level high, 0 = off level low). While `drv_en` is 1, `bout` equals `bdrv_raw`.
- R3: While `drv_en` is 1 and `alarm` is 0, `hout` equals `hdrv_raw`.
- R4: The `xray_in` input passes through two synchronizer flops. A 1 sampled on `xray_in` at clock edge k sets `alarm` after edge k+2. While `alarm` is 1, `hout` is 1 regardless of `drv_en`.
- R5: `alarm` holds its value until the synchronized overvoltage input is 0 and `alarm_clr` is sampled 1, or until reset. If the synchronized input is 1 in the same cycle as `alarm_clr`, `alarm` stays 1.
- R6: `hsoft_req` is 1 for exactly the one cycle after an edge at which `drv_en` is sampled 1 and was sampled 0 at the previous edge. The state during reset counts as 0.
- R7: `bsoft_req` is 1 in the cycle after such an edge only if `ext_saw` is also sampled 1 at that edge. Otherwise it stays 0.
- R8: `ph_strobe` is 1 for the one cycle after an edge at which `ext_saw` and `ph_mode` are both 1 and `hdrv_raw` has changed from its previous sampled value. The change must be 0 to 1 when `ph_edge_rise` is 1, and 1 to 0 when it is 0. The previous sample of `hdrv_raw` counts as 0 after reset.
- R9: With either `ext_saw` or `ph_mode` at 0, `ph_strobe` stays 0 for any edge and any `ph_edge_rise`.
- R10: While `rst_n` is 0, `alarm`, `hsoft_req`, `bsoft_req` and `ph_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdrv_raw | input | 1 | Raw horizontal drive pulse |
| bdrv_raw | input | 1 | Raw B+ converter drive pulse |
| drv_en | input | 1 | Drive enable |
| bpol | input | 1 | B+ output off level |
| ph_mode | input | 1 | Phase B+ output from horizontal drive |
| ph_edge_rise | input | 1 | Phasing edge: 1 rising, 0 falling |
| ext_saw | input | 1 | Converter in external-sawtooth mode |
| xray_in | input | 1 | Overvoltage comparator, asynchronous |
| alarm_clr | input | 1 | Clear the overvoltage alarm |
| hout | output | 1 | Gated horizontal drive pin |
| bout | output | 1 | Gated B+ drive pin |
| hsoft_req | output | 1 | Horizontal soft-start request pulse |
| bsoft_req | output | 1 | B+ soft-start request pulse |
| ph_strobe | output | 1 | B+ phase trigger strobe |
| alarm | output | 1 | Sticky overvoltage alarm |

## Verification
The bench drives random pulse trains on both raw drives while toggling the enable and the two polarity and edge controls. This separates passthrough from forced-off levels, and a high B+ off level from a low one. Rare random overvoltage pulses and clear writes show that the alarm is sticky and that it inhibits only the horizontal pin. A directed case holds the overvoltage input high during a clear, to show that the event wins. Enable rises are tried with and without external-sawtooth mode, which shows whether the B+ request is qualified correctly. Strobes are tried under every combination of mode bits, so that falling-edge and rising-edge phasing are distinguished from the ignored case.

// File: rtl/defl_pkg.sv
package defl_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } phase_edge_e;

  localparam int unsigned XRAY_SYNC_STAGES = 2;
endpackage

// File: rtl/defl_xray_latch.sv
module defl_xray_latch #(
  parameter int unsigned SYNC_STAGES = defl_pkg::XRAY_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_async,
  input  logic clr,
  output logic alarm_q
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  logic          alarm_d;
  logic          trip_s;

  assign trip_s = sync_q[LAST];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = trip_async;
    end else begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], trip_async};
    end
  endgenerate

  always_comb begin
    alarm_d = alarm_q;
    if (trip_s)   alarm_d = 1'b1;
    else if (clr) alarm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      alarm_q <= alarm_d;
    end
  end
endmodule

// File: rtl/defl_softstart.sv
module defl_softstart (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ext_saw,
  output logic hreq_q,
  output logic breq_q
);
  logic en_q;
  logic rise;
  logic hreq_d, breq_d;

  always_comb begin
    rise   = en & ~en_q;
    hreq_d = rise;
    breq_d = rise & ext_saw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hreq_q <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      en_q   <= en;
      hreq_q <= hreq_d;
      breq_q <= breq_d;
    end
  end
endmodule

// File: rtl/defl_phase_edge.sv
module defl_phase_edge
  import defl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drv,
  input  logic        arm,
  input  phase_edge_e sel,
  output logic        strobe_q
);
  logic drv_q;
  logic rise, fall, hit;

  always_comb begin
    rise = drv & ~drv_q;
    fall = ~drv & drv_q;
    hit  = arm & ((sel == EDGE_RISE) ? rise : fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      drv_q    <= drv;
      strobe_q <= hit;
    end
  end
endmodule

// File: rtl/defl_drive_gate.sv
module defl_drive_gate
  import defl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = XRAY_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdrv_raw,
  input  logic bdrv_raw,
  input  logic drv_en,
  input  logic bpol,
  input  logic ph_mode,
  input  logic ph_edge_rise,
  input  logic ext_saw,
  input  logic xray_in,
  input  logic alarm_clr,
  output logic hout,
  output logic bout,
  output logic hsoft_req,
  output logic bsoft_req,
  output logic ph_strobe,
  output logic alarm
);
  localparam logic HOFF_LEVEL = 1'b1;

  logic        h_pass;
  logic        phase_arm;
  phase_edge_e edge_sel;

  defl_xray_latch #(.SYNC_STAGES(SYNC_STAGES)) u_xray (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_async(xray_in),
    .clr       (alarm_clr),
    .alarm_q   (alarm)
  );

  defl_softstart u_soft (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (drv_en),
    .ext_saw(ext_saw),
    .hreq_q (hsoft_req),
    .breq_q (bsoft_req)
  );

  always_comb begin
    phase_arm = ext_saw & ph_mode;
    edge_sel  = ph_edge_rise ? EDGE_RISE : EDGE_FALL;
    h_pass    = drv_en & ~alarm;
    hout      = h_pass ? hdrv_raw : HOFF_LEVEL;
    bout      = drv_en ? bdrv_raw : bpol;
  end

  defl_phase_edge u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv     (hdrv_raw),
    .arm     (phase_arm),
    .sel     (edge_sel),
    .strobe_q(ph_strobe)
  );
endmodule

// File: rtl/defl_drive_gate_chk.sv
module defl_drive_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic drv_en,
  input logic bpol,
  input logic ph_mode,
  input logic ext_saw,
  input logic alarm_clr,
  input logic hout,
  input logic bout,
  input logic hsoft_req,
  input logic bsoft_req,
  input logic ph_strobe,
  input logic alarm
);
  AST_HOUT_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> hout); // R1
  AST_BOUT_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (bout == bpol)); // R2
  AST_HOUT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> hout); // R4
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm); // R5
  AST_SOFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hsoft_req |=> !hsoft_req); // R6
  AST_BSOFT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    bsoft_req |-> hsoft_req); // R7
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_strobe) |-> $past(ext_saw && ph_mode)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(alarm || hsoft_req || bsoft_req || ph_strobe)); // R10
endmodule

bind defl_drive_gate defl_drive_gate_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drv_en   (drv_en),
  .bpol     (bpol),
  .ph_mode  (ph_mode),
  .ext_saw  (ext_saw),
  .alarm_clr(alarm_clr),
  .hout     (hout),
  .bout     (bout),
  .hsoft_req(hsoft_req),
  .bsoft_req(bsoft_req),
  .ph_strobe(ph_strobe),
  .alarm    (alarm)
);

// File: tb/test_defl_drive_gate.sv
module test_defl_drive_gate;
  logic clk = 1'b0;
  logic rst_n;
  logic hdrv_raw, bdrv_raw, drv_en, bpol, ph_mode, ph_edge_rise;
  logic ext_saw, xray_in, alarm_clr;
  logic hout, bout, hsoft_req, bsoft_req, ph_strobe, alarm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic m_s1, m_s2, m_alarm, m_en, m_hsoft, m_bsoft, m_hd, m_strobe;

  always #5 clk = ~clk;

  defl_drive_gate i_defl_drive_gate (
    .clk(clk), .rst_n(rst_n), .hdrv_raw(hdrv_raw), .bdrv_raw(bdrv_raw),
    .drv_en(drv_en), .bpol(bpol), .ph_mode(ph_mode), .ph_edge_rise(ph_edge_rise),
    .ext_saw(ext_saw), .xray_in(xray_in), .alarm_clr(alarm_clr),
    .hout(hout), .bout(bout), .hsoft_req(hsoft_req), .bsoft_req(bsoft_req),
    .ph_strobe(ph_strobe), .alarm(alarm)
  );

  function automatic logic exp_hout(logic en, logic al, logic h);
    return (en && !al) ? h : 1'b1;
  endfunction

  function automatic logic exp_bout(logic en, logic pol, logic b);
    return en ? b : pol;
  endfunction

  function automatic logic exp_strobe(logic saw, logic md, logic rise, logic h, logic hp);
    return saw & md & (rise ? (h & ~hp) : (~h & hp));
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  task automatic check_all();
    string th;
    th = !drv_en ? "R1 hout" : (m_alarm ? "R4 hout" : "R3 hout");
    chk(th, hout, exp_hout(drv_en, m_alarm, hdrv_raw));
    chk("R2 bout", bout, exp_bout(drv_en, bpol, bdrv_raw));
    chk("R5 alarm", alarm, m_alarm);
    chk("R6 hsoft_req", hsoft_req, m_hsoft);
    chk("R7 bsoft_req", bsoft_req, m_bsoft);
    chk((ext_saw && ph_mode) ? "R8 ph_strobe" : "R9 ph_strobe", ph_strobe, m_strobe);
  endtask

  task automatic model_edge();
    logic na;
    na = m_s2 ? 1'b1 : (alarm_clr ? 1'b0 : m_alarm);
    m_alarm  = na;
    m_s2     = m_s1;
    m_s1     = xray_in;
    m_hsoft  = drv_en & ~m_en;
    m_bsoft  = drv_en & ~m_en & ext_saw;
    m_en     = drv_en;
    m_strobe = exp_strobe(ext_saw, ph_mode, ph_edge_rise, hdrv_raw, m_hd);
    m_hd     = hdrv_raw;
  endtask

  // inputs already set after negedge; check, then advance one edge
  task automatic step();
    #1;
    check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_alarm = 0; m_en = 0;
    m_hsoft = 0; m_bsoft = 0; m_hd = 0; m_strobe = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    rst_n = 0; hdrv_raw = 1; bdrv_raw = 0; drv_en = 1; bpol = 1;
    ph_mode = 1; ph_edge_rise = 1; ext_saw = 1; xray_in = 1; alarm_clr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state while inputs are active
    chk("R10 alarm", alarm, 1'b0);
    chk("R10 hsoft_req", hsoft_req, 1'b0);
    chk("R10 bsoft_req", bsoft_req, 1'b0);
    chk("R10 ph_strobe", ph_strobe, 1'b0);
    drv_en = 0; xray_in = 0; hdrv_raw = 0;
    @(negedge clk);
    rst_n = 1;

    // R6/R7: enable rise without then with external sawtooth
    ext_saw = 0; step();
    drv_en = 1; step(); step(); step();
    drv_en = 0; ext_saw = 1; step();
    drv_en = 1; step(); step();
    // R4/R5: alarm set, clear while event still present keeps it set
    xray_in = 1; step(); step(); step();
    alarm_clr = 1; step(); step();
    xray_in = 0; step(); step(); step(); step();
    alarm_clr = 0; step();
    // R9: edges ignored without phase mode, both edge choices
    ph_mode = 0;
    for (int i = 0; i < 8; i++) begin
      hdrv_raw = ~hdrv_raw; ph_edge_rise = i[1]; step();
    end
    // R8: falling then rising phasing
    ph_mode = 1; ext_saw = 1;
    for (int i = 0; i < 8; i++) begin
      hdrv_raw = ~hdrv_raw; ph_edge_rise = i[2]; step();
    end

    for (int i = 0; i < 3000; i++) begin
      hdrv_raw  = $urandom_range(0, 1);
      bdrv_raw  = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) drv_en = ~drv_en;
      if ($urandom_range(0, 19) == 0) bpol = ~bpol;
      if ($urandom_range(0, 15) == 0) ph_mode = ~ph_mode;
      if ($urandom_range(0, 15) == 0) ph_edge_rise = ~ph_edge_rise;
      if ($urandom_range(0, 15) == 0) ext_saw = ~ext_saw;
      xray_in   = ($urandom_range(0, 39) == 0);
      alarm_clr = ($urandom_range(0, 7) == 0);
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule